// File: doc/BRIEF.md
# IR Remote Data Signal Generator

This block produces the baseband data waveform for an infrared remote transmitter. A counter of `CW` bits, 16 by default, counts up from zero. While it runs, the output is high until the count reaches a duty compare value. It is then low until the count reaches a cycle compare value. In repeat mode the counter wraps to zero and the pattern repeats. In one-shot mode the counter stops at the cycle value and the run bit clears itself.

Software drives the block through a small word-wide register port with a write strobe and a combinational read. The control word holds these fields: enable, run, self-clearing software reset, one-shot select, compare-buffer enable and output inversion. With buffering on, new duty and cycle values wait in shadow registers and take effect at the next cycle match, so the running period is never disturbed. Two sticky match flags drive a single interrupt output. Software clears each flag by writing 1 to its bit.

Top module: `irdata_gen`

## Requirements
- R1: After reset the counter reads 0, both flags read 0, the control word reads 0, and `data_o` and `irq_o` are 0. The register map is: address 0 control, 1 duty compare, 2 cycle compare, 3 live counter (read-only, writes ignored), 4 flags.
- R2: The counter advances by one per clock only while enable (control bit 0) and run (control bit 8) are both 1. With run at 1 and enable at 0 it does not move. Writing run 0 holds it at its current value.
- R3: In repeat mode (control bit 2 = 0), the cycle after the count equals the active cycle compare the counter reads 0, so one period lasts cycle+1 clocks.
- R4: `data_o` equals (counting and count < active duty) XOR the invert bit (control bit 4). When not counting it equals the invert bit.
- R5: In one-shot mode (control bit 2 = 1), a cycle match clears the run bit and the counter holds at the cycle value. A control write in the same cycle takes priority over this clear.
- R6: With buffering off (control bit 3 = 0), writes to addresses 1 and 2 update the active compare directly. With buffering on they update only the shadow, and a cycle match copies both shadows into the active compares. Reads of addresses 1 and 2 return the active values.
- R7: A duty match sets flag bit 0 and a cycle match sets flag bit 1. Each flag stays set until software writes 1 to its bit at address 4; a new match in the same cycle takes priority over the clear. `irq_o` is the OR of the two flags.
- R8: Writing 1 to control bit 1 makes that bit read 1 for exactly one cycle. In that cycle the counter holds, and the next edge clears the counter and both flags. Writing 0 to the bit does nothing.
- R9: Control bits 7 to 5 read as 0 whatever value is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| we | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | CW | Write data |
| rdata | output | CW | Read data for `addr` (combinational) |
| data_o | output | 1 | Data waveform output |
| irq_o | output | 1 | Interrupt, OR of the two match flags |

## Verification
The checker tests the following on every clock:
- the counter holds whenever it is stopped;
- it steps by exactly one between matches;
- it wraps in repeat mode;
- it halts and drops run in one-shot mode;
- the output shows only the polarity bit while idle;
- flags stay set unless cleared;
- the reset pulse lasts one cycle and clears counter and flags.

Other behaviours need a sequence of register operations, so only the bench scenarios show them: shadow values taking effect exactly at the period boundary, reserved bits reading zero, ignored writes to the counter, and the run bit having no effect while the block is disabled. The bench model compares `data_o` and `irq_o` every clock and checks register reads at chosen points.

// File: rtl/irdata_gen.sv
module irdata_gen #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [2:0]    addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  output logic          data_o,
  output logic          irq_o
);
  localparam int RUNB = 8;

  logic en, run, oneshot, bufen, inv, busy;
  logic [CW-1:0] cnt, duty_a, cyc_a, duty_s, cyc_s;
  logic fd, fc;

  wire wr_ctl   = we && addr == 3'd0;
  wire wr_duty  = we && addr == 3'd1;
  wire wr_cyc   = we && addr == 3'd2;
  wire wr_flag  = we && addr == 3'd4;
  wire counting = en && run && !busy;
  wire dmatch   = counting && cnt == duty_a;
  wire cmatch   = counting && cnt == cyc_a;

  assign data_o = (counting && cnt < duty_a) ^ inv;
  assign irq_o  = fd | fc;

  always_comb begin
    rdata = '0;
    case (addr)
      3'd0: begin
        rdata[0] = en; rdata[1] = busy; rdata[2] = oneshot;
        rdata[3] = bufen; rdata[4] = inv; rdata[RUNB] = run;
      end
      3'd1: rdata = duty_a;
      3'd2: rdata = cyc_a;
      3'd3: rdata = cnt;
      3'd4: rdata[1:0] = {fc, fd};
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {en, run, oneshot, bufen, inv, busy} <= '0;
    end else begin
      busy <= wr_ctl && wdata[1];
      if (wr_ctl) begin
        en      <= wdata[0];
        oneshot <= wdata[2];
        bufen   <= wdata[3];
        inv     <= wdata[4];
        run     <= wdata[RUNB];
      end else if (cmatch && oneshot) begin
        run <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      fd  <= 1'b0;
      fc  <= 1'b0;
    end else if (busy) begin
      cnt <= '0;
      fd  <= 1'b0;
      fc  <= 1'b0;
    end else begin
      if (counting)
        cnt <= cmatch ? (oneshot ? cnt : '0) : cnt + 1'b1;
      fd <= dmatch | (fd & ~(wr_flag & wdata[0]));
      fc <= cmatch | (fc & ~(wr_flag & wdata[1]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_a <= '0; cyc_a <= '0; duty_s <= '0; cyc_s <= '0;
    end else begin
      if (cmatch && bufen) begin
        duty_a <= duty_s;
        cyc_a  <= cyc_s;
      end
      if (wr_duty) begin
        duty_s <= wdata;
        if (!bufen) duty_a <= wdata;
      end
      if (wr_cyc) begin
        cyc_s <= wdata;
        if (!bufen) cyc_a <= wdata;
      end
    end
  end
endmodule

module irdata_gen_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          we,
  input logic [2:0]    addr,
  input logic [CW-1:0] wdata,
  input logic          en,
  input logic          run,
  input logic          oneshot,
  input logic          busy,
  input logic          inv,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] cyc_a,
  input logic          fd,
  input logic          fc,
  input logic          data_o
);
  wire cnting = en && run && !busy;
  wire ctl_wr = we && addr == 3'd0;
  wire flg_wr = we && addr == 3'd4;

  a_r2_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnting && !busy) |=> $stable(cnt));
  a_r2_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (cnting && cnt != cyc_a) |=> cnt == $past(cnt) + 1'b1);
  a_r3_repeat_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnting && !oneshot && cnt == cyc_a) |=> cnt == '0);
  a_r5_oneshot_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (cnting && oneshot && cnt == cyc_a && !ctl_wr) |=> (!run && $stable(cnt)));
  a_r4_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !cnting |-> data_o == inv);
  a_r7_cycle_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fc && !busy && !(flg_wr && wdata[1])) |=> fc);
  a_r7_duty_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fd && !busy && !(flg_wr && wdata[0])) |=> fd);
  a_r8_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (cnt == '0 && !fd && !fc));
  a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(ctl_wr && wdata[1])) |=> !busy);
endmodule

bind irdata_gen irdata_gen_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
  .en(en), .run(run), .oneshot(oneshot), .busy(busy), .inv(inv),
  .cnt(cnt), .cyc_a(cyc_a), .fd(fd), .fc(fc), .data_o(data_o)
);

// File: tb/irdata_gen_tb.sv
module irdata_gen_tb;
  logic clk = 0, rst_n = 0, we = 0;
  logic [2:0] addr = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic data_o, irq_o;
  int nvec = 0, nbad = 0;
  bit done = 0;

  irdata_gen u_dut (.clk(clk), .rst_n(rst_n), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .data_o(data_o), .irq_o(irq_o));

  always #10 clk = ~clk;

  // reference state
  bit m_en, m_run, m_os, m_buf, m_inv, m_busy, m_fd, m_fc;
  int m_cnt, m_da, m_ca, m_ds, m_cs;

  function automatic int exp_rd(input int a);
    case (a)
      0: return (int'(m_run) << 8) | (int'(m_inv) << 4) | (int'(m_buf) << 3)
              | (int'(m_os) << 2) | (int'(m_busy) << 1) | int'(m_en);
      1: return m_da;
      2: return m_ca;
      3: return m_cnt;
      4: return (int'(m_fc) << 1) | int'(m_fd);
      default: return 0;
    endcase
  endfunction

  task automatic model_step();
    bit cnting, dm, cm, wc;
    int n_cnt, n_da, n_ca;
    cnting = m_en && m_run && !m_busy;
    dm = cnting && m_cnt == m_da;
    cm = cnting && m_cnt == m_ca;
    wc = we && addr == 0;
    n_cnt = m_cnt; n_da = m_da; n_ca = m_ca;
    if (m_busy) n_cnt = 0;
    else if (cnting) n_cnt = cm ? (m_os ? m_cnt : 0) : (m_cnt + 1) & 16'hFFFF;
    if (m_busy) begin m_fd = 0; m_fc = 0; end
    else begin
      m_fd = dm || (m_fd && !(we && addr == 4 && wdata[0]));
      m_fc = cm || (m_fc && !(we && addr == 4 && wdata[1]));
    end
    if (cm && m_buf) begin n_da = m_ds; n_ca = m_cs; end
    if (we && addr == 1) begin m_ds = wdata; if (!m_buf) n_da = wdata; end
    if (we && addr == 2) begin m_cs = wdata; if (!m_buf) n_ca = wdata; end
    if (wc) begin
      m_en = wdata[0]; m_os = wdata[2]; m_buf = wdata[3];
      m_inv = wdata[4]; m_run = wdata[8];
    end else if (cm && m_os) m_run = 0;
    m_busy = wc && wdata[1];
    m_cnt = n_cnt; m_da = n_da; m_ca = n_ca;
  endtask

  task automatic check(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input string req);
    bit m_out;
    @(posedge clk);
    model_step();
    @(negedge clk);
    m_out = ((m_en && m_run && !m_busy && m_cnt < m_da) ? 1'b1 : 1'b0) ^ m_inv;
    check({req, " data_o"}, int'(data_o), int'(m_out));
    check({req, " irq_o"}, int'(irq_o), int'(m_fd | m_fc));
  endtask

  task automatic run_cycles(input int n, input string req);
    for (int i = 0; i < n; i++) tick(req);
  endtask

  task automatic wr(input int a, input int d, input string req);
    we = 1; addr = 3'(a); wdata = 16'(d);
    tick(req);
    we = 0;
  endtask

  task automatic rd(input int a, input string req);
    addr = 3'(a);
    #1;
    check({req, " read"}, int'(rdata), exp_rd(a));
  endtask

  task automatic rd_exp(input int a, input int exp, input string req);
    addr = 3'(a);
    #1;
    check({req, " read"}, int'(rdata), exp);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      nbad++; nvec++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 data_o", int'(data_o), 0);
    check("R1 irq_o", int'(irq_o), 0);
    rd_exp(0, 0, "R1 ctrl");
    rd_exp(3, 0, "R1 cnt");
    rd_exp(4, 0, "R1 flags");
    // R6 direct loading
    wr(1, 3, "R6"); wr(2, 6, "R6");
    rd_exp(1, 3, "R6 duty direct"); rd_exp(2, 6, "R6 cycle direct");
    // R2 run without enable
    wr(0, 16'h100, "R2");
    run_cycles(5, "R2");
    rd_exp(3, 0, "R2 no count while disabled");
    // R3 R4 repeat mode
    wr(0, 16'h101, "R3");
    run_cycles(4, "R3");
    rd_exp(3, 4, "R3 count after 5 cycles");
    run_cycles(3, "R3");
    rd_exp(3, 0, "R3 wrapped");
    run_cycles(15, "R4");
    rd(3, "R3");
    // R2 stop holds
    wr(0, 16'h001, "R2 stop");
    rd(3, "R2 stop");
    run_cycles(4, "R2 hold");
    rd(3, "R2 held value");
    // R7 flags set, clear
    rd_exp(4, 3, "R7 both flags set");
    wr(4, 1, "R7 clear duty");
    rd_exp(4, 2, "R7 cycle flag kept");
    wr(4, 2, "R7 clear cycle");
    rd_exp(4, 0, "R7 flags cleared");
    // R4 inversion
    wr(0, 16'h111, "R4 invert");
    run_cycles(16, "R4 invert");
    wr(0, 16'h011, "R4 idle inverted");
    check("R4 idle level", int'(data_o), 1);
    // R9 reserved bits
    wr(0, 16'h0E1, "R9");
    rd_exp(0, 1, "R9 reserved read 0");
    // R1 counter write ignored
    rd(3, "R1");
    wr(3, 16'h1234, "R1 cnt write");
    rd(3, "R1 cnt write ignored");
    // R8 software reset, write 0 no effect
    wr(0, 16'h001, "R8 zero write");
    rd(3, "R8 zero write no effect");
    wr(0, 16'h003, "R8 reset");
    rd_exp(0, 3, "R8 busy reads 1");
    tick("R8");
    rd_exp(0, 1, "R8 self clear");
    rd_exp(3, 0, "R8 cnt cleared");
    rd_exp(4, 0, "R8 flags cleared");
    // R6 buffered loading
    wr(0, 16'h109, "R6 buffered run");
    run_cycles(2, "R6");
    wr(1, 1, "R6 shadow"); wr(2, 9, "R6 shadow");
    rd_exp(1, 3, "R6 duty unchanged"); rd_exp(2, 6, "R6 cycle unchanged");
    run_cycles(4, "R6");
    rd_exp(2, 9, "R6 cycle loaded at match");
    rd_exp(1, 1, "R6 duty loaded at match");
    run_cycles(25, "R6");
    // R5 one-shot
    wr(0, 16'h003, "R5 reset");
    tick("R5");
    wr(0, 16'h105, "R5 oneshot");
    run_cycles(14, "R5");
    rd_exp(0, 5, "R5 run cleared");
    rd_exp(3, 9, "R5 holds at cycle");
    run_cycles(3, "R5 idle");
    rd_exp(3, 9, "R5 still held");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule